// File: doc/BRIEF.md
# Single-Precision Result Packer

This block turns an unpacked floating-point value into a 32-bit IEEE-754 single-precision word. The value arrives as a sign, a class code, an unbiased exponent and a wide mantissa. The mantissa holds the leading one explicitly, and the bits below the single-precision fraction serve as guard, round and sticky information. The selected rounding mode is applied in the same pass. Four sticky status flags record underflow, overflow, inexact results and invalid-operation conditions.

The packer accepts one value per clock when `in_valid` is high. The packed word appears on `out_word` one cycle later, together with `out_valid`. The flags collect events across many results. A pulse on `flag_clr` zeroes them so that a surrounding status register can fold them in.

Top module: `sp_packer`

## Requirements
- R1: `out_valid` is high in exactly the cycle after an accepted input (`in_valid` high at a rising edge) and low otherwise; `out_word` then holds that input's packed result, and both are low/zero after reset.
- R2: Class codes: 0 zero, 1 finite number, 2 infinity, 3 NaN. A zero packs as the sign bit followed by 31 zero bits. An infinity packs as the sign, exponent field 0xFF and fraction 0. Neither sets any flag.
- R3: A NaN packs as the sign, exponent 0xFF and fraction `in_mant[30:8]`. The quiet bit is taken as already set in the mantissa, and no flag is set.
- R4: For a finite value, the biased exponent is `in_exp + 127`. In the normal case, `in_mant[31:8]` is the 24-bit significand, bit 7 is guard, bit 6 is round, and bits 5:0 OR `in_sticky` form sticky. Rounding modes are 0 nearest-even, 1 toward zero, 2 toward +infinity and 3 toward -infinity. The directed modes round up only when the value is inexact. Inexact is flagged whenever guard, round or sticky is set.
- R5: When a normal rounds up to 2.0, the exponent field is one higher and the fraction is zero.
- R6: A biased exponent of 0 or less always sets underflow. The fraction is `in_mant` shifted right by `9 - biased` places and then rounded, and the exponent field is 0.
- R7: When a subnormal rounds up to 2^23, the result becomes the smallest normal: exponent field 1, fraction 0.
- R8: When a normal's biased exponent after rounding is 255 or more, the overflow, inexact and operand-error flags are all set.
- R9: On overflow, the result is infinity in nearest mode, toward +infinity for positive values and toward -infinity for negative values. In all other cases it is the sign, exponent 254 and an all-ones fraction.
- R10: Flags hold their value until cleared. A `flag_clr` pulse in a cycle with no input leaves all four flags at zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value present this cycle |
| in_sign | input | 1 | Sign of the value |
| in_class | input | 2 | 0 zero, 1 finite, 2 infinity, 3 NaN |
| in_exp | input | EXP_W (12) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (32) | Mantissa, leading one at the top bit |
| in_sticky | input | 1 | Sticky bit from earlier arithmetic |
| rnd_mode | input | 2 | Rounding mode code |
| flag_clr | input | 1 | Zero the sticky flags |
| out_valid | output | 1 | Packed word valid |
| out_word | output | 32 | Packed single-precision word |
| flag_unfl | output | 1 | Sticky underflow |
| flag_ovfl | output | 1 | Sticky overflow |
| flag_inex | output | 1 | Sticky inexact |
| flag_operr | output | 1 | Sticky operand error |

## Verification
Exact powers of two show that the exponent bias and alignment are right without any rounding. Patterns with guard/round/sticky set at tie and off-tie points, under every mode and both signs, show the round-up decision apart from the truncation path. Boundary exponents are driven to exercise the transitions: the smallest normal against the largest subnormal, all-ones mantissas that carry into the exponent or promote a subnormal, the top exponents that spill into overflow, and very deep negative exponents that collapse entirely into sticky. A run of random values spread across the subnormal-to-overflow range is checked against an independently written bit-serial model.

// File: rtl/sp_packer.sv
module sp_packer #(
  parameter int MANT_W = 32,
  parameter int EXP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic [1:0]              in_class,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  logic [1:0]              rnd_mode,
  input  logic                    flag_clr,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    flag_unfl,
  output logic                    flag_ovfl,
  output logic                    flag_inex,
  output logic                    flag_operr
);

  localparam int XW  = MANT_W + 2;
  localparam int NSH = MANT_W - 24;
  localparam int BW  = EXP_W + 2;
  localparam int SHW = $clog2(XW + 1);
  localparam logic signed [BW-1:0] BIAS     = 127;
  localparam logic signed [BW-1:0] EINF     = 255;
  localparam logic signed [BW-1:0] SUB_BASE = NSH + 1;
  localparam logic signed [BW-1:0] SH_MAX   = XW;

  localparam logic [1:0] CL_ZERO = 2'd0, CL_FIN = 2'd1, CL_INF = 2'd2, CL_NAN = 2'd3;
  localparam logic [1:0] RM_NEAR = 2'd0, RM_ZERO = 2'd1, RM_PINF = 2'd2, RM_MINF = 2'd3;

  logic signed [BW-1:0] be, sh_raw, be_post;
  logic                 is_sub;
  logic [SHW-1:0]       sh;
  logic [XW-1:0]        ext, drop_mask;
  logic [25:0]          kept;
  logic [23:0]          sig;
  logic [24:0]          sig_rnd;
  logic                 g, r, s, inexact, up, ovf, to_inf;
  logic [31:0]          word_n;
  logic                 unfl_n, ovfl_n, inex_n, operr_n;

  assign be      = BW'(in_exp) + BIAS;
  assign is_sub  = (be <= 0);
  assign sh_raw  = is_sub ? (SUB_BASE - be) : BW'(NSH);
  assign sh      = (sh_raw > SH_MAX) ? SHW'(XW) : SHW'(sh_raw);

  assign ext       = {in_mant, 2'b00};
  assign kept      = 26'(ext >> sh);
  assign drop_mask = ~({XW{1'b1}} << sh);
  assign sig       = kept[25:2];
  assign g         = kept[1];
  assign r         = kept[0];
  assign s         = (|(ext & drop_mask)) | in_sticky;
  assign inexact   = g | r | s;

  always_comb begin
    case (rnd_mode)
      RM_NEAR: begin up = g & (r | s | sig[0]); to_inf = 1'b1;     end
      RM_ZERO: begin up = 1'b0;                 to_inf = 1'b0;     end
      RM_PINF: begin up = inexact & ~in_sign;   to_inf = ~in_sign; end
      default: begin up = inexact & in_sign;    to_inf = in_sign;  end
    endcase
  end

  assign sig_rnd = {1'b0, sig} + 25'(up);
  assign be_post = be + BW'(sig_rnd[24]);
  assign ovf     = !is_sub && (be_post >= EINF);

  always_comb begin
    word_n  = {in_sign, 31'b0};
    unfl_n  = 1'b0;
    ovfl_n  = 1'b0;
    inex_n  = 1'b0;
    operr_n = 1'b0;
    case (in_class)
      CL_NAN:  word_n = {in_sign, 8'hFF, in_mant[MANT_W-2 -: 23]};
      CL_INF:  word_n = {in_sign, 8'hFF, 23'b0};
      CL_FIN: begin
        inex_n = inexact;
        if (is_sub) begin
          unfl_n = 1'b1;
          word_n = {in_sign, 7'b0, sig_rnd[23], sig_rnd[22:0]};
        end else if (ovf) begin
          ovfl_n  = 1'b1;
          inex_n  = 1'b1;
          operr_n = 1'b1;
          word_n  = to_inf ? {in_sign, 8'hFF, 23'b0} : {in_sign, 8'hFE, {23{1'b1}}};
        end else begin
          word_n = {in_sign, be_post[7:0], sig_rnd[22:0]};
        end
      end
      default: word_n = {in_sign, 31'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_word   <= '0;
      flag_unfl  <= 1'b0;
      flag_ovfl  <= 1'b0;
      flag_inex  <= 1'b0;
      flag_operr <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      if (in_valid) out_word <= word_n;
      flag_unfl  <= (flag_unfl  & ~flag_clr) | (in_valid & unfl_n);
      flag_ovfl  <= (flag_ovfl  & ~flag_clr) | (in_valid & ovfl_n);
      flag_inex  <= (flag_inex  & ~flag_clr) | (in_valid & inex_n);
      flag_operr <= (flag_operr & ~flag_clr) | (in_valid & operr_n);
    end
  end

endmodule

// File: rtl/sp_packer_chk.sv
module sp_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_sign,
  input logic [1:0]  in_class,
  input logic        flag_clr,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        flag_unfl,
  input logic        flag_ovfl,
  input logic        flag_inex,
  input logic        flag_operr
);

  logic [3:0] flags;
  assign flags = {flag_unfl, flag_ovfl, flag_inex, flag_operr};

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  zero_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd0) |=> (out_word == {$past(in_sign), 31'b0}));

  // R2
  inf_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 2'd2) |=> (out_word == {$past(in_sign), 8'hFF, 23'b0}));

  // R8
  ovfl_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_ovfl) |-> (flag_inex && flag_operr));

  // R10
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !in_valid) |=> (flags == 4'b0));

endmodule

bind sp_packer sp_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
  .in_class(in_class), .flag_clr(flag_clr), .out_valid(out_valid),
  .out_word(out_word), .flag_unfl(flag_unfl), .flag_ovfl(flag_ovfl),
  .flag_inex(flag_inex), .flag_operr(flag_operr)
);

// File: tb/sp_packer_tb.sv
module sp_packer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0, in_sticky = 1'b0, flag_clr = 1'b0;
  logic [1:0] in_class = 2'd0, rnd_mode = 2'd0;
  logic signed [11:0] in_exp = '0;
  logic [31:0] in_mant = '0;
  logic out_valid;
  logic [31:0] out_word;
  logic flag_unfl, flag_ovfl, flag_inex, flag_operr;

  always #2.5 clk = ~clk;

  sp_packer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .rnd_mode(rnd_mode), .flag_clr(flag_clr), .out_valid(out_valid),
    .out_word(out_word), .flag_unfl(flag_unfl), .flag_ovfl(flag_ovfl),
    .flag_inex(flag_inex), .flag_operr(flag_operr)
  );

  typedef struct {
    logic [31:0] w;
    logic [3:0]  f;
    string       tag;
  } item_t;

  item_t q[$];
  int nchk = 0, nbad = 0;
  logic [3:0] acc = 4'b0;
  bit finished = 0;

  // returns {unfl, ovfl, inex, operr, word}
  function automatic logic [35:0] ref_pack(input logic sg, input logic [1:0] cl,
      input int ex, input logic [31:0] mt, input logic st, input logic [1:0] md);
    longint m;
    int be, n;
    logic sk, gb, rb, inx, rup, uf;
    logic [31:0] w;
    if (cl == 2'd3) return {4'b0, sg, 8'hFF, mt[30:8]};
    if (cl == 2'd2) return {4'b0, sg, 8'hFF, 23'b0};
    if (cl == 2'd0) return {4'b0, sg, 31'b0};
    be = ex + 127;
    uf = (be <= 0);
    n  = uf ? (9 - be) : 8;
    m  = longint'(mt);
    sk = st;
    for (int i = 0; i < n - 2; i++) begin
      sk = sk | m[0];
      m = m >> 1;
    end
    gb = m[1];
    rb = m[0];
    m = m >> 2;
    inx = gb | rb | sk;
    case (md)
      2'd0: rup = gb && (rb || sk || m[0]);
      2'd1: rup = 1'b0;
      2'd2: rup = inx && !sg;
      default: rup = inx && sg;
    endcase
    if (rup) m = m + 1;
    if (uf) begin
      if (m == (64'd1 << 23)) w = {sg, 8'd1, 23'd0};
      else w = {sg, 8'd0, m[22:0]};
      return {1'b1, 1'b0, inx, 1'b0, w};
    end
    if (m == (64'd1 << 24)) begin
      be = be + 1;
      m = 0;
    end
    if (be >= 255) begin
      if (md == 2'd0 || (md == 2'd2 && !sg) || (md == 2'd3 && sg))
        w = {sg, 8'hFF, 23'd0};
      else
        w = {sg, 8'hFE, 23'h7FFFFF};
      return {4'b0111, w};
    end
    w = {sg, be[7:0], m[22:0]};
    return {1'b0, 1'b0, inx, 1'b0, w};
  endfunction

  task automatic send(input logic sg, input logic [1:0] cl, input int ex,
      input logic [31:0] mt, input logic st, input logic [1:0] md, input string tag);
    logic [35:0] res;
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_sign = sg; in_class = cl; in_exp = 12'(ex);
    in_mant = mt; in_sticky = st; rnd_mode = md;
    res = ref_pack(sg, cl, ex, mt, st, md);
    acc = acc | res[35:32];
    it.w = res[31:0];
    it.f = acc;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    in_valid = 1'b0;
    flag_clr = 1'b1;
    acc = 4'b0;
    @(negedge clk);
    flag_clr = 1'b0;
    nchk++;
    if ({flag_unfl, flag_ovfl, flag_inex, flag_operr} != 4'b0) begin
      nbad++;
      $display("FAIL R10 flags after clear: got %b expected 0000",
               {flag_unfl, flag_ovfl, flag_inex, flag_operr});
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (q.size() == 0) begin
        nchk++; nbad++;
        $display("FAIL R1 unexpected out_valid: got 1 expected 0");
      end else begin
        item_t e;
        e = q.pop_front();
        nchk++;
        if (out_word !== e.w) begin
          nbad++;
          $display("FAIL %s word: got %h expected %h", e.tag, out_word, e.w);
        end
        nchk++;
        if ({flag_unfl, flag_ovfl, flag_inex, flag_operr} !== e.f) begin
          nbad++;
          $display("FAIL %s flags(u,o,i,e): got %b expected %b", e.tag,
                   {flag_unfl, flag_ovfl, flag_inex, flag_operr}, e.f);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    nchk++;
    if (out_valid !== 1'b0 || out_word !== 32'h0 ||
        {flag_unfl, flag_ovfl, flag_inex, flag_operr} !== 4'b0) begin
      nbad++;
      $display("FAIL R1 reset state: got v=%b w=%h f=%b expected 0", out_valid, out_word,
               {flag_unfl, flag_ovfl, flag_inex, flag_operr});
    end
    rst_n = 1'b1;
    idle();

    // R2 zero and infinity
    send(1'b1, 2'd0, 0, 32'h0, 1'b0, 2'd0, "R2");
    send(1'b0, 2'd0, 5, 32'h8000_0000, 1'b1, 2'd2, "R2");
    send(1'b1, 2'd2, 0, 32'h0, 1'b0, 2'd1, "R2");
    send(1'b0, 2'd2, 0, 32'h0, 1'b0, 2'd3, "R2");
    // R3 NaN
    send(1'b0, 2'd3, 0, 32'hC000_1234, 1'b0, 2'd0, "R3");
    send(1'b1, 2'd3, 0, 32'hFFFF_FFFF, 1'b1, 2'd1, "R3");
    idle();
    // R1 gap check: output must drop
    @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0) begin
      nbad++;
      $display("FAIL R1 valid after idle: got %b expected 0", out_valid);
    end

    // R4 exact and rounding, all modes, both signs
    send(1'b0, 2'd1, 0, 32'h8000_0000, 1'b0, 2'd0, "R4");
    send(1'b1, 2'd1, -3, 32'hA000_0000, 1'b0, 2'd0, "R4");
    clear_flags();
    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        send(sg[0], 2'd1, 1, 32'h8000_0080, 1'b0, md[1:0], "R4");
        send(sg[0], 2'd1, 1, 32'h8000_0180, 1'b0, md[1:0], "R4");
        send(sg[0], 2'd1, 2, 32'h8000_0040, 1'b0, md[1:0], "R4");
        send(sg[0], 2'd1, 2, 32'h8000_0100, 1'b1, md[1:0], "R4");
        send(sg[0], 2'd1, 2, 32'h8000_00C1, 1'b0, md[1:0], "R4");
      end
    end
    clear_flags();
    // R5 round to 2.0
    send(1'b0, 2'd1, 3, 32'hFFFF_FF80, 1'b0, 2'd0, "R5");
    send(1'b1, 2'd1, -126, 32'hFFFF_FFFF, 1'b0, 2'd3, "R5");
    send(1'b0, 2'd1, 3, 32'hFFFF_FF80, 1'b0, 2'd1, "R5");
    clear_flags();
    // R6 subnormals and the normal boundary
    send(1'b0, 2'd1, -126, 32'h8000_0000, 1'b0, 2'd0, "R6");
    send(1'b0, 2'd1, -127, 32'h8000_0000, 1'b0, 2'd0, "R6");
    clear_flags();
    send(1'b1, 2'd1, -149, 32'h8000_0000, 1'b0, 2'd0, "R6");
    send(1'b0, 2'd1, -150, 32'h8000_0000, 1'b0, 2'd0, "R6");
    send(1'b0, 2'd1, -150, 32'h8000_0001, 1'b0, 2'd0, "R6");
    send(1'b0, 2'd1, -140, 32'h9234_5678, 1'b0, 2'd2, "R6");
    send(1'b1, 2'd1, -2000, 32'h8000_0000, 1'b0, 2'd3, "R6");
    send(1'b0, 2'd1, -2000, 32'h8000_0000, 1'b0, 2'd1, "R6");
    // R7 subnormal promotes to smallest normal
    send(1'b0, 2'd1, -127, 32'hFFFF_FFFF, 1'b0, 2'd0, "R7");
    send(1'b1, 2'd1, -127, 32'hFFFF_FE00, 1'b1, 2'd3, "R7");
    send(1'b1, 2'd1, -127, 32'hFFFF_FE00, 1'b1, 2'd2, "R7");
    clear_flags();
    // R8 / R9 overflow
    send(1'b0, 2'd1, 127, 32'hFFFF_FF00, 1'b0, 2'd0, "R8");
    clear_flags();
    for (int md = 0; md < 4; md++) begin
      for (int sg = 0; sg < 2; sg++) begin
        send(sg[0], 2'd1, 127, 32'hFFFF_FF80, 1'b0, md[1:0], "R9");
        send(sg[0], 2'd1, 200, 32'h8000_0000, 1'b0, md[1:0], "R9");
      end
      clear_flags();
    end
    send(1'b0, 2'd1, 128, 32'h8000_0000, 1'b0, 2'd1, "R8");
    clear_flags();

    // random sweep
    for (int k = 0; k < 400; k++) begin
      int ex;
      logic [31:0] mt;
      ex = int'($urandom_range(300)) - 160;
      mt = $urandom() | 32'h8000_0000;
      send(1'($urandom_range(1)), 2'd1, ex, mt, 1'($urandom_range(1)),
           2'($urandom_range(3)), "R4");
      if (k % 50 == 49) clear_flags();
    end
    idle();
    repeat (4) @(negedge clk);
    nchk++;
    if (q.size() != 0) begin
      nbad++;
      $display("FAIL R1 results missing: got %0d pending expected 0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule